// File: doc/BRIEF.md
# Memory-to-Stream Read Adapter

This block reads a contiguous run of words from a memory bank and hands them, in address order, to a downstream processing unit as a flow-controlled stream. Software sets a start word address and a word count in a small register window, then writes the start bit. After that it polls a status bit and a running count of the words the consumer has taken.

On the memory side the block issues read requests with a request/acknowledge handshake. Read data comes back later and in order, marked by a separate valid strobe. On the stream side a valid/ready pair lets the consumer stall for as long as it likes. A four-entry return buffer catches the data that comes back. The block only issues a request when the returned and in-flight words together leave room in that buffer, so nothing is ever dropped while the stream is stalled.

Each instance decodes its own 0x200-byte window. A parameter selects whether the programmed address and length survive a start (persistent) or are consumed by it.

Top module: `mem_stream_reader`

## Requirements
- R1: After reset the control register reads 0 (not busy, not done), the count register reads 0, and neither `st_valid` nor `mem_req` is asserted.
- R2: The window base is 0x5000 + 0x200 × INDEX. Registers sit at byte offsets 0x0 (control), 0x4 (start word address), 0x8 (word count) and 0xC (words delivered, read-only). Writes to any other address, including unused offsets inside the window, change nothing.
- R3: Writing control bit 0 = 1 while idle streams the words at addresses A, A+1, …, A+L−1, in that order, with each word equal to the memory data returned for its address.
- R4: `mem_req` and `mem_addr` hold steady until `mem_ack`. Each acknowledged request moves the address on by one, and exactly L requests are acknowledged per transfer.
- R5: Acknowledged requests whose words the consumer has not yet accepted never exceed 4. With the stream fully stalled, exactly 4 requests are acknowledged.
- R6: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_data` and `st_last` stay unchanged.
- R7: The count register is cleared by an accepted start, goes up by one per accepted stream beat, and ends equal to L.
- R8: `st_last` is high on the final beat of a transfer only.
- R9: Control bit 1 (busy) is high while a transfer is running. Control bit 2 (done) is high once the count equals L, and stays low from the accepted start until then.
- R10: A start written while busy has no effect: the running transfer, its count and its requests continue unchanged.
- R11: A start with L = 0 sets done without any request or stream beat.
- R12: With PERSIST=1, the address and count registers keep their values across a start, so a new start re-reads the same region. With PERSIST=0, an accepted start clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational, 0 outside the window) |
| mem_req | output | 1 | Read request |
| mem_ack | input | 1 | Request accepted |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | DW | Write data, tied to 0 (read-only port) |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| st_valid | output | 1 | Stream word valid |
| st_ready | input | 1 | Consumer ready |
| st_data | output | DW | Stream word |
| st_last | output | 1 | Final word of the transfer |

## Verification
The hardest situation to reach is the one where the return buffer is full, requests are blocked by the credit limit, and the stream is stalled, all at the same time. The bench gets there on purpose. It holds `st_ready` low while the memory acknowledges every request, then checks that exactly four requests go out. While that stall lasts it also issues a second start, which must be ignored. Random runs then mix acknowledge rates, return latencies and ready rates, so the buffer fills and drains in many orders.

// File: rtl/mem_stream_reader.sv
module mem_stream_reader #(
  parameter int AW      = 20,
  parameter int DW      = 32,
  parameter int LW      = 16,
  parameter int DEPTH   = 4,
  parameter int INDEX   = 0,
  parameter bit PERSIST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [15:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  input  logic          mem_ack,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [DW-1:0] st_data,
  output logic          st_last
);
  localparam logic [15:0] BASE = 16'(16'h5000 + INDEX * 16'h0200);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q, run_addr;
  logic [LW-1:0] len_q, run_len, issued, done_cnt;
  logic          active, ran;
  logic [DW-1:0] buf_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, pend;

  wire       hit    = reg_addr[15:9] == BASE[15:9] && reg_addr[8:4] == 5'd0 && reg_addr[1:0] == 2'd0;
  wire [1:0] offs   = reg_addr[3:2];
  wire       wr_hit = reg_wr && hit;
  wire       go     = wr_hit && offs == 2'd0 && reg_wdata[0] && !active;
  wire       acc    = mem_req && mem_ack;
  wire       pop    = st_valid && st_ready;
  wire       fin    = pop && done_cnt == run_len - LW'(1);

  assign mem_req   = active && issued != run_len && ({1'b0, pend} + {1'b0, cnt}) < (CW+1)'(DEPTH);
  assign mem_addr  = run_addr;
  assign mem_wdata = '0;
  assign st_valid  = cnt != '0;
  assign st_data   = buf_q[rd_ptr];
  assign st_last   = st_valid && done_cnt == run_len - LW'(1);

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (offs)
        2'd0: reg_rdata = {29'd0, ran && !active, active, 1'b0};
        2'd1: reg_rdata = 32'(addr_q);
        2'd2: reg_rdata = 32'(len_q);
        default: reg_rdata = 32'(done_cnt);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      len_q    <= '0;
      run_addr <= '0;
      run_len  <= '0;
      issued   <= '0;
      done_cnt <= '0;
      active   <= 1'b0;
      ran      <= 1'b0;
    end else begin
      if (wr_hit && offs == 2'd1) addr_q <= AW'(reg_wdata);
      if (wr_hit && offs == 2'd2) len_q  <= LW'(reg_wdata);
      if (go) begin
        run_addr <= addr_q;
        run_len  <= len_q;
        issued   <= '0;
        done_cnt <= '0;
        active   <= len_q != '0;
        ran      <= 1'b1;
        if (!PERSIST) begin
          addr_q <= '0;
          len_q  <= '0;
        end
      end else if (active) begin
        if (acc) begin
          run_addr <= run_addr + AW'(1);
          issued   <= issued + LW'(1);
        end
        if (pop) done_cnt <= done_cnt + LW'(1);
        if (fin) active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      pend   <= '0;
    end else begin
      pend <= pend + CW'(acc) - CW'(mem_rvalid);
      cnt  <= cnt + CW'(mem_rvalid) - CW'(pop);
      if (mem_rvalid) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (pop)        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (mem_rvalid) buf_q[wr_ptr] <= mem_rdata;
  end
endmodule

// File: rtl/mem_stream_reader_chk.sv
module mem_stream_reader_chk #(
  parameter int AW    = 20,
  parameter int DW    = 32,
  parameter int LW    = 16,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          st_valid,
  input logic          st_ready,
  input logic [DW-1:0] st_data,
  input logic          st_last,
  input logic          active,
  input logic [LW-1:0] issued,
  input logic [LW-1:0] run_len,
  input logic [$clog2(DEPTH+1)-1:0] pend,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r4_issue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> issued <= run_len);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pend) + 32'(cnt)) <= DEPTH);

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last));

  a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    st_last |-> st_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req);
endmodule

bind mem_stream_reader mem_stream_reader_chk #(.AW(AW), .DW(DW), .LW(LW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_last(st_last),
  .active(active), .issued(issued), .run_len(run_len), .pend(pend), .cnt(cnt)
);

// File: tb/mem_stream_reader_tb_top.sv
module mem_stream_reader_tb_top;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam logic [15:0] B1 = 16'h5400;
  localparam logic [15:0] B0 = 16'h5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          reg_wr = 1'b0;
  logic [15:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   rdata1, rdata0;
  logic          mem_req, mem_ack = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic          st_valid, st_ready = 1'b0, st_last;
  logic [DW-1:0] st_data;

  logic          np_req, np_sv, np_sl;
  logic [AW-1:0] np_addr;
  logic [DW-1:0] np_wd, np_sd;

  mem_stream_reader #(.AW(AW), .DW(DW), .INDEX(2), .PERSIST(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata1), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_last(st_last));

  mem_stream_reader #(.AW(AW), .DW(DW), .INDEX(0), .PERSIST(1'b0)) np_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata0), .mem_req(np_req), .mem_ack(1'b0), .mem_addr(np_addr),
    .mem_wdata(np_wd), .mem_rvalid(1'b0), .mem_rdata('0),
    .st_valid(np_sv), .st_ready(1'b1), .st_data(np_sd), .st_last(np_sl));

  int total = 0, fails = 0;
  int exp_base = 0, exp_len = 0, ack_i = 0, beat_i = 0;
  int ready_pct = 100, ack_pct = 100;
  bit hold_ready = 1'b0, was_stalled = 1'b0;
  logic [DW-1:0] stall_data;
  logic [AW-1:0] q[$];

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      st_ready = hold_ready ? 1'b0 : (($urandom % 100) < ready_pct);
      mem_ack  = ($urandom % 100) < ack_pct;
      if (q.size() > 0 && ($urandom % 100) < 60) begin
        mem_rvalid = 1'b1;
        mem_rdata  = word_of(q.pop_front());
      end else begin
        mem_rvalid = 1'b0;
      end
      #1;
      if (was_stalled) check(st_valid && st_data == stall_data, "R6 stall hold", st_data, stall_data);
      was_stalled = st_valid && !st_ready;
      stall_data  = st_data;
      if (mem_req && mem_ack) begin
        check(mem_addr == AW'(exp_base + ack_i), "R4 request address", mem_addr, AW'(exp_base + ack_i));
        check(ack_i < exp_len, "R4 request count", ack_i + 1, exp_len);
        q.push_back(mem_addr);
        ack_i++;
      end
      if (st_valid && st_ready) begin
        check(st_data == word_of(AW'(exp_base + beat_i)), "R3 stream word", st_data, word_of(AW'(exp_base + beat_i)));
        check(st_last == (beat_i == exp_len - 1), "R8 last flag", st_last, beat_i == exp_len - 1);
        beat_i++;
      end
      if (ack_i - beat_i > 4) check(1'b0, "R5 credit", ack_i - beat_i, 4);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2;
    d = (a[15:9] == B1[15:9]) ? rdata1 : rdata0;
  endtask

  task automatic launch(input int a, input int l);
    wr(B1 + 16'h4, 32'(a));
    wr(B1 + 16'h8, 32'(l));
    exp_base = a; exp_len = l; ack_i = 0; beat_i = 0;
    wr(B1, 32'h1);
  endtask

  task automatic wait_done(input int l, input string tag);
    logic [31:0] v;
    int n = 0;
    do begin rd(B1, v); n++; end while (!v[2] && n < 20000);
    check(v[2] == 1'b1 && v[1] == 1'b0, {tag, " R9 done"}, v, 32'h4);
    rd(B1 + 16'hC, v);
    check(v == 32'(l), {tag, " R7 count"}, v, l);
    check(beat_i == l, {tag, " R3 beats"}, beat_i, l);
    check(ack_i == l, {tag, " R4 acks"}, ack_i, l);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(B1, v);        check(v == 0, "R1 control", v, 0);
    rd(B1 + 16'hC, v); check(v == 0, "R1 count", v, 0);
    check(!st_valid && !mem_req, "R1 outputs", {st_valid, mem_req}, 0);

    wr(B1 + 16'h8, 32'd9);
    wr(B1 + 16'h18, 32'd77);
    rd(B1 + 16'h8, v); check(v == 9, "R2 unused offset ignored", v, 9);
    rd(B0 + 16'h8, v); check(v == 0, "R2 other window untouched", v, 0);

    wr(B0 + 16'h4, 32'h30);
    wr(B0 + 16'h8, 32'd5);
    wr(B0, 32'h1);
    rd(B0 + 16'h8, v); check(v == 0, "R12 non-persistent length cleared", v, 0);
    rd(B0 + 16'h4, v); check(v == 0, "R12 non-persistent address cleared", v, 0);
    rd(B0, v);         check(v[1] == 1'b1, "R9 busy bit", v, 2);

    ack_pct = 100; hold_ready = 1'b1;
    launch(32'h100, 10);
    repeat (30) @(negedge clk);
    check(ack_i == 4, "R5 stalled credit", ack_i, 4);
    rd(B1, v);         check(v[2:1] == 2'b01, "R9 busy not done", v, 2);
    rd(B1 + 16'hC, v); check(v == 0, "R7 count while stalled", v, 0);
    wr(B1 + 16'h4, 32'h777);
    wr(B1 + 16'h8, 32'd3);
    wr(B1, 32'h1);
    repeat (5) @(negedge clk);
    check(ack_i == 4, "R10 start ignored acks", ack_i, 4);
    rd(B1, v); check(v[1] == 1'b1, "R10 still busy", v, 2);
    hold_ready = 1'b0; ready_pct = 50;
    wait_done(10, "stall run");

    rd(B1 + 16'h8, v); check(v == 3, "R12 persistent length kept", v, 3);
    rd(B1 + 16'h4, v); check(v == 32'h777, "R12 persistent address kept", v, 32'h777);
    exp_base = 32'h777; exp_len = 3; ack_i = 0; beat_i = 0;
    wr(B1, 32'h1);
    wait_done(3, "R12 rerun");

    launch(32'h2000, 0);
    repeat (6) @(negedge clk);
    rd(B1, v); check(v[2:1] == 2'b10, "R11 zero length done", v, 4);
    check(ack_i == 0 && beat_i == 0, "R11 no activity", ack_i + beat_i, 0);

    for (int i = 0; i < 14; i++) begin
      int a, l;
      a = int'($urandom % 32'h100000);
      l = 1 + int'($urandom % 40);
      ready_pct = 20 + int'($urandom % 81);
      ack_pct   = 20 + int'($urandom % 81);
      if (i == 0) a = 32'hFFFFE;
      launch(a, l);
      wait_done(l, "random run");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule